// File: doc/BRIEF.md
# Three-Wire Serial Register Slave for a Display Timing Controller

This block is the control port of a display timing controller. A host reaches a small register file through three wires: an active-low chip select, a serial clock and one bidirectional data line. The line is shared by both ends. The host drives it during the command bits and during write data. The slave drives it only while it returns read data. The register file holds a scratch register that the host uses to test the link, a fixed identity byte, a resolution code, and a control byte. The control byte holds a standby bit and a bit that chooses whether resolution and standby come from the registers or from external strap pins.

All three serial inputs are brought into the core clock domain through synchronisers. Serial clock edges are found by comparing successive synchronised samples. The serial clock must therefore run no faster than one eighth of the core clock. The host must also wait a few core cycles between lowering chip select and the first clock edge. The idle level of the serial clock is high, so each bit begins with a falling edge and ends with a rising edge. Write and read frames differ in length. The slave tells them apart after the seventh command bit.

Top module: `spi3_regslave`

## Requirements
- R1: A write frame is 16 bits, sent MSB first and sampled on rising serial clock edges. The first byte carries the register address in bits 7:2 and 0b00 in bits 1:0. The second byte is the data, which is committed after the 16th rising edge.
- R2: A read frame starts with a 7-bit command that holds the address in bits 6:1 and a 1 in bit 0. The slave then returns 8 data bits MSB first. Each bit is launched on a falling edge and is valid at the following rising edge.
- R3: The slave enables its driver on the falling edge that follows the 7th command bit of a read. It releases the driver on the falling edge that follows the host's sampling of the last data bit. The driver is never enabled during command bits, during write frames, or while chip select is high.
- R4: Address 0 is a scratch register whose 8 bits are all writable and read back unchanged. Its value changes only after a completed write to it.
- R5: Address 1 reads as the chip identifier in bits 7:4 and the revision in bits 3:0 (0x31 by default). Writes to it have no effect.
- R6: Address 2 stores a 3-bit resolution code in bits 2:0. Bits 7:3 read as 0. The code resets to 0b111.
- R7: Address 3 stores a standby bit in bit 0 (1 = panel on) and a source-select bit in bit 7. The other bits read as 0. The register resets to 0x00.
- R8: When bit 7 of address 3 is 1, the resolution and panel-on outputs follow the registers. When it is 0, they follow the strap-pin inputs.
- R9: Raising chip select before a frame is complete aborts that frame with no register change and releases the data line. The next frame is decoded from its first bit.
- R10: A write command whose bits 1:0 are not 0b00 is discarded. Addresses 4 to 63 read as 0x00 and ignore writes.
- R11: After the active-low reset, the scratch register is 0x00, the resolution code is 0b111, and the control byte is 0x00. The data line is released and the outputs follow the strap pins.
- R12: Once a frame is complete, further clock edges are ignored until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock, idle high |
| sdio_in | input | 1 | Level seen on the shared data line |
| sdio_out | output | 1 | Value the slave drives onto the data line |
| sdio_oe | output | 1 | Driver enable for the data line |
| pin_res | input | 3 | Strap-pin resolution code |
| pin_on | input | 1 | Strap-pin panel-on level |
| res_code | output | 3 | Resolution code in effect |
| panel_on | output | 1 | Panel-on level in effect (0 = standby) |

## Verification
A corrupted bit counter or frame state shows up inside the frame where it happens. If the driver enable opens during command bits or stays on past the eighth read bit, the line is seen at the next sampling edge. A slip in counting shifts read data by one or more positions, which the next read frame exposes. A wrong stored value or a missing write strobe stays hidden until the register is read back or, for addresses 2 and 3, appears on the resolution and panel-on outputs a few core cycles after the 16th rising edge. For that reason every write in the sequence is followed by a read of the same address.

// File: rtl/spi3_pkg.sv
package spi3_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int RES_W  = 3;
    localparam int CMD_RD_BITS = 7;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_IDENT   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_RES     = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(3);

    localparam int MODE_ON_BIT  = 0;
    localparam int MODE_SEL_BIT = 7;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_CMD,
        FR_TURN,
        FR_RDATA,
        FR_WDATA,
        FR_SKIP
    } frame_st_e;

    typedef struct packed {
        frame_st_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  sh;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  rsh;
        logic               oe;
        logic               sdo;
        logic               wr;
        logic [DATA_W-1:0]  wdata;
    } frame_s;

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [RES_W-1:0]  res;
        logic              sel;
        logic              on;
    } regs_s;

endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
    parameter int              W      = 3,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST    = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] chain_q [STAGES+1];
    logic [W-1:0] chain_d [STAGES+1];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i <= STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
    import spi3_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_hi,
    input  logic               rise,
    input  logic               fall,
    input  logic               din,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  addr,
    output logic               wr_en,
    output logic [DATA_W-1:0]  wr_data,
    output logic               sdo,
    output logic               oe
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] RD_BIT   = CNT_W'(CMD_RD_BITS - 1);

    frame_s q, d;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (cs_hi) begin
            d.st  = FR_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                FR_IDLE: begin
                    d.st  = FR_CMD;
                    d.cnt = '0;
                    d.sh  = '0;
                end
                FR_CMD: begin
                    if (rise) begin
                        d.sh  = {q.sh[DATA_W-2:0], din};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == RD_BIT && din) begin
                            d.st   = FR_TURN;
                            d.addr = q.sh[ADDR_W-1:0];
                        end else if (q.cnt == LAST_BIT) begin
                            if (!din && !q.sh[0]) begin
                                d.st   = FR_WDATA;
                                d.addr = q.sh[ADDR_W:1];
                                d.cnt  = '0;
                            end else begin
                                d.st = FR_SKIP;
                            end
                        end
                    end
                end
                FR_TURN: begin
                    if (fall) begin
                        d.oe  = 1'b1;
                        d.sdo = rd_data[DATA_W-1];
                        d.rsh = {rd_data[DATA_W-2:0], 1'b0};
                        d.cnt = '0;
                        d.st  = FR_RDATA;
                    end
                end
                FR_RDATA: begin
                    if (fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = FR_SKIP;
                        end else begin
                            d.sdo = q.rsh[DATA_W-1];
                            d.rsh = {q.rsh[DATA_W-2:0], 1'b0};
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                FR_WDATA: begin
                    if (rise) begin
                        d.sh  = {q.sh[DATA_W-2:0], din};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT) begin
                            d.wr    = 1'b1;
                            d.wdata = {q.sh[DATA_W-2:0], din};
                            d.st    = FR_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FR_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign addr    = q.addr;
    assign wr_en   = q.wr;
    assign wr_data = q.wdata;
    assign sdo     = q.sdo;
    assign oe      = q.oe;

    // R3: line released once chip select has been high for a cycle
    assert_oe_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi && $past(cs_hi)) |-> !q.oe);

    // R2: driver turns on only at a falling serial clock edge
    assert_oe_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> $past(fall));

    // R2: a launched bit holds until the next falling edge
    assert_sdo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe && $past(q.oe) && !$past(fall)) |-> $stable(q.sdo));

    // R12: no write strobe while skipping to end of frame
    assert_no_late_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st == FR_SKIP)) |-> !q.wr);

endmodule

// File: rtl/spi3_regs.sv
module spi3_regs
    import spi3_pkg::*;
#(
    parameter logic [3:0]       CHIP_ID     = 4'h3,
    parameter logic [3:0]       REVISION    = 4'h1,
    parameter logic [RES_W-1:0] RES_DEFAULT = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic [RES_W-1:0]   res_reg,
    output logic               sel_reg,
    output logic               on_reg
);

    regs_s q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (addr)
                A_SCRATCH: d.scratch = wr_data;
                A_RES:     d.res     = wr_data[RES_W-1:0];
                A_MODE: begin
                    d.sel = wr_data[MODE_SEL_BIT];
                    d.on  = wr_data[MODE_ON_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_SCRATCH: rd_data = q.scratch;
            A_IDENT:   rd_data = {CHIP_ID, REVISION};
            A_RES:     rd_data[RES_W-1:0] = q.res;
            A_MODE: begin
                rd_data[MODE_SEL_BIT] = q.sel;
                rd_data[MODE_ON_BIT]  = q.on;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scratch: '0, res: RES_DEFAULT, sel: 1'b0, on: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign res_reg = q.res;
    assign sel_reg = q.sel;
    assign on_reg  = q.on;

    // R4: scratch changes only in the cycle after a write strobe
    assert_scratch_only_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(q.scratch));

    // R7: control byte changes only in the cycle after a write strobe
    assert_mode_only_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(q.sel) && $stable(q.on)));

endmodule

// File: rtl/spi3_regslave.sv
module spi3_regslave
    import spi3_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [3:0]       CHIP_ID     = 4'h3,
    parameter logic [3:0]       REVISION    = 4'h1,
    parameter logic [RES_W-1:0] RES_DEFAULT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdio_in,
    output logic             sdio_out,
    output logic             sdio_oe,
    input  logic [RES_W-1:0] pin_res,
    input  logic             pin_on,
    output logic [RES_W-1:0] res_code,
    output logic             panel_on
);

    localparam int IDX_CS = 2;
    localparam int IDX_CK = 1;
    localparam int IDX_DI = 0;

    logic [2:0]        s_now, s_prev;
    logic              rise, fall;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [RES_W-1:0]  res_reg;
    logic              sel_reg, on_reg;

    spi3_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST    (3'b111)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, sdio_in}),
        .sync_o  (s_now),
        .prev_o  (s_prev)
    );

    assign rise = s_now[IDX_CK] & ~s_prev[IDX_CK];
    assign fall = ~s_now[IDX_CK] & s_prev[IDX_CK];

    spi3_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_hi   (s_now[IDX_CS]),
        .rise    (rise),
        .fall    (fall),
        .din     (s_now[IDX_DI]),
        .rd_data (rd_data),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sdo     (sdio_out),
        .oe      (sdio_oe)
    );

    spi3_regs #(
        .CHIP_ID     (CHIP_ID),
        .REVISION    (REVISION),
        .RES_DEFAULT (RES_DEFAULT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .res_reg (res_reg),
        .sel_reg (sel_reg),
        .on_reg  (on_reg)
    );

    assign res_code = sel_reg ? res_reg : pin_res;
    assign panel_on = sel_reg ? on_reg  : pin_on;

endmodule

// File: tb/spi3_regslave_tb.sv
`timescale 1ns/1ps
module spi3_regslave_tb;

    localparam int HALF = 8;
    localparam int NVEC = 20;

    // {write, addr[5:0], data[7:0], expect[7:0], req[3:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 6'd0,  8'h00, 8'h00, 4'd11},  // R11 scratch default
        {1'b0, 6'd1,  8'h00, 8'h31, 4'd5 },  // R5 identity
        {1'b0, 6'd2,  8'h00, 8'h07, 4'd6 },  // R6 default code
        {1'b0, 6'd3,  8'h00, 8'h00, 4'd7 },  // R7 default control
        {1'b1, 6'd0,  8'h55, 8'h00, 4'd1 },  // R1 write
        {1'b0, 6'd0,  8'h00, 8'h55, 4'd4 },  // R4
        {1'b1, 6'd0,  8'hAA, 8'h00, 4'd4 },
        {1'b0, 6'd0,  8'h00, 8'hAA, 4'd4 },
        {1'b1, 6'd1,  8'hFF, 8'h00, 4'd5 },  // R5 write ignored
        {1'b0, 6'd1,  8'h00, 8'h31, 4'd5 },
        {1'b1, 6'd2,  8'hFA, 8'h00, 4'd6 },  // R6 masked
        {1'b0, 6'd2,  8'h00, 8'h02, 4'd6 },
        {1'b1, 6'd3,  8'hFF, 8'h00, 4'd7 },  // R7 masked
        {1'b0, 6'd3,  8'h00, 8'h81, 4'd7 },
        {1'b1, 6'd5,  8'h12, 8'h00, 4'd10},  // R10 unmapped
        {1'b0, 6'd5,  8'h00, 8'h00, 4'd10},
        {1'b1, 6'd63, 8'h77, 8'h00, 4'd10},
        {1'b0, 6'd63, 8'h00, 8'h00, 4'd10},
        {1'b1, 6'd0,  8'hC3, 8'h00, 4'd1 },
        {1'b0, 6'd0,  8'h00, 8'hC3, 4'd2 }   // R2 read
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic       host_oe = 1'b0;
    logic       host_bit = 1'b1;
    logic [2:0] pin_res = 3'd4;
    logic       pin_on = 1'b1;
    logic       sdio_out, sdio_oe, panel_on;
    logic [2:0] res_code;
    wire        line = sdio_oe ? sdio_out : (host_oe ? host_bit : 1'b1);

    int n_chk = 0;
    int n_fail = 0;
    int oe_err = 0;

    always #2.5 clk = ~clk;

    spi3_regslave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sdio_in  (line),
        .sdio_out (sdio_out),
        .sdio_oe  (sdio_oe),
        .pin_res  (pin_res),
        .pin_on   (pin_on),
        .res_code (res_code),
        .panel_on (panel_on)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        sclk = 1'b0;
        host_bit = b;
        tick(HALF);
        if (sdio_oe) oe_err++;
        sclk = 1'b1;
        tick(HALF);
    endtask

    task automatic frame_start();
        host_oe = 1'b1;
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_end();
        sclk = 1'b1;
        tick(HALF);
        cs_n = 1'b1;
        host_oe = 1'b0;
        tick(2*HALF);
        if (sdio_oe) oe_err++;
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic spi_write(input logic [5:0] a, input logic [7:0] v);
        frame_start();
        put_byte({a, 2'b00});
        put_byte(v);
        frame_end();
    endtask

    task automatic spi_read(input logic [5:0] a, output logic [7:0] v);
        logic [6:0] cmd;
        cmd = {a, 1'b1};
        v = '0;
        frame_start();
        for (int i = 6; i >= 0; i--) put_bit(cmd[i]);
        host_oe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0;
            tick(HALF);
            if (!sdio_oe) oe_err++;
            v = {v[6:0], line};
            sclk = 1'b1;
            tick(HALF);
        end
        sclk = 1'b0;
        tick(HALF);
        if (sdio_oe) oe_err++;
        frame_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        tick(10);
        rst_n = 1'b1;
        tick(4);
        // R11: reset state at the ports
        check("R11 oe", {7'b0, sdio_oe}, 8'h00);
        check("R11 res", {5'b0, res_code}, {5'b0, pin_res});
        check("R11 on", {7'b0, panel_on}, {7'b0, pin_on});

        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][26]) begin
                spi_write(VEC[k][25:20], VEC[k][19:12]);
            end else begin
                oe_err = 0;
                spi_read(VEC[k][25:20], rd);
                n_chk++;
                if (rd !== VEC[k][11:4]) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VEC[k][3:0], k, rd, VEC[k][11:4]);
                end
                check("R3 driver window", 8'(oe_err), 8'h00);
            end
        end

        // R8: register source (control = 0x81, code = 2)
        pin_res = 3'd5; pin_on = 1'b0;
        tick(2);
        check("R8 reg res", {5'b0, res_code}, 8'h02);
        check("R8 reg on", {7'b0, panel_on}, 8'h01);
        spi_write(6'd3, 8'h00);
        check("R8 pin res", {5'b0, res_code}, 8'h05);
        check("R8 pin on", {7'b0, panel_on}, 8'h00);
        pin_on = 1'b1; pin_res = 3'd3;
        tick(2);
        check("R8 pin follow", {4'b0, res_code, panel_on}, 8'h07);

        // R9: abort a write after 12 bits
        frame_start();
        put_byte(8'h00);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        frame_end();
        spi_read(6'd0, rd);
        check("R9 aborted write", rd, 8'hC3);
        // R9: abort a read in its data phase, line must be released
        frame_start();
        for (int i = 0; i < 7; i++) put_bit(i == 6);
        host_oe = 1'b0;
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b0; tick(HALF); sclk = 1'b1; tick(HALF);
        end
        sclk = 1'b0; tick(HALF);
        cs_n = 1'b1;
        tick(2*HALF);
        check("R9 release", {7'b0, sdio_oe}, 8'h00);
        sclk = 1'b1; tick(HALF);
        spi_write(6'd0, 8'h5A);
        spi_read(6'd0, rd);
        check("R9 restart", rd, 8'h5A);

        // R10: command with bits 1:0 = 01 is discarded
        frame_start();
        put_byte(8'b000000_01);
        put_byte(8'h22);
        frame_end();
        spi_read(6'd0, rd);
        check("R10 bad command", rd, 8'h5A);

        // R12: extra bits after a full write frame are ignored
        frame_start();
        put_byte(8'h00);
        put_byte(8'h3C);
        put_byte(8'hFF);
        frame_end();
        spi_read(6'd0, rd);
        check("R12 trailing bits", rd, 8'h3C);

        // R11: reset restores defaults
        spi_write(6'd2, 8'h01);
        spi_write(6'd3, 8'h80);
        check("R11 pre-reset sel", {5'b0, res_code}, 8'h01);
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        check("R11 outputs to pins", {5'b0, res_code}, {5'b0, pin_res});
        spi_read(6'd0, rd);
        check("R11 scratch", rd, 8'h00);
        spi_read(6'd2, rd);
        check("R11 res", rd, 8'h07);
        spi_read(6'd3, rd);
        check("R11 control", rd, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule